// File: doc/BRIEF.md
# Ping-pong DMA buffer descriptor sequencer

This block runs the system-memory side of one DMA channel using two alternating pages, called ping and pong. It keeps a 128-bit descriptor, organised as eight 16-bit words. The descriptor holds:

- a channel enable bit;
- a byte-order select bit;
- a page pointer;
- for each page, a ready flag, a done flag and an error flag;
- for each page, a depth and a 32-bit base address.

Software programs the descriptor through a word-wide write port and reads it back through a combinational read port.

While the channel is enabled and the page under the pointer is armed, the block requests one byte per cycle on a simple memory-master interface. The interface has a request, a byte address and a byte-lane strobe, and the memory answers with an accept signal and an error signal. The block walks the page from its base address up to base plus depth. Then it:

- marks the page done;
- disarms the page;
- pulses an interrupt;
- flips the page pointer.

If the other page is already armed, the next request follows in the very next cycle. Bus errors are latched into the error flag of the page being served. Software clears the done and error flags by writing zero to them.

Top module: `pingpong_dma_seq`

## Requirements
- R1: After reset every descriptor word reads 0, `mem_req` is 0 and `done_irq` is 0.
- R2: Word 0 holds enable (bit 15), byte order (bit 14) and page pointer (bit 13); its other bits read 0. Word 1 reads 0 and ignores writes. Words 2 (ping) and 3 (pong) hold ready (bit 15), done (bit 14), error (bit 13) and depth (bits 12:0). Words 4/5 are the ping base address low/high half, and words 6/7 are the pong base address low/high half. Readable fields read back what was written.
- R3: `mem_req` is 1 exactly when enable is 1 and the active page is ready. `mem_addr` is the active base plus a byte offset. The offset starts at 0 and grows by 1 for each cycle in which `mem_req` and `mem_ack` are both 1.
- R4: The acceptance of the byte at base plus depth completes the page. In the following cycle:
  - the page's done flag is 1;
  - its ready flag is 0;
  - the page pointer is inverted;
  - the offset is 0;
  - `done_irq` is 1, for that single cycle.
- R5: If the other page is ready at completion, its first request appears in the cycle right after the completing acceptance, so pages run without a gap. If it is not ready, `mem_req` stays 0.
- R6: Writing 0 to a done or error bit clears it. Writing 1 leaves it unchanged, so software can never set these bits.
- R7: `mem_err` high during an accepted request sets the error flag of the active page. The transfer carries on.
- R8: When a hardware set of a done or error flag coincides with a software write of 0 to the same bit, the flag ends up 1.
- R9: `mem_strb` is one-hot while `mem_req` is 1. With byte order 1 (little endian) the strobe bit is address bits 1:0. With byte order 0 (big endian) it is 3 minus address bits 1:0.
- R10: With enable at 0, `mem_req` is 0, and the offset and page pointer keep their values. Setting enable again resumes at the same address.
- R11: `mem_ack` while `mem_req` is 0 has no effect on the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Descriptor word write strobe |
| cfg_wr_idx | input | 3 | Index of the word written |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_idx | input | 3 | Index of the word read |
| cfg_rd_data | output | 16 | Read data (combinational) |
| mem_req | output | 1 | Byte transfer request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_strb | output | 4 | Byte-lane strobe within the 32-bit bus word |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_err | input | 1 | Error response for the accepted request |
| done_irq | output | 1 | One-cycle pulse per completed page |

## Verification
The sharp case is a page completion that falls in the same cycle as a software write of zeros to that page's flag word. The bench arms a two-byte page and times a second write so that it lands on the clock edge that accepts the last byte. That byte is also answered with an error. The bench then reads the flag word back and expects both done and error to be 1 and ready to be 0. The gapless hand-over between pages is judged separately, from the cycle stamps of the accepted requests and of the interrupt.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;
  localparam int NPAGE = 2;

  localparam logic [2:0] IDX_CTRL    = 3'd0;
  localparam logic [2:0] IDX_RSVD    = 3'd1;
  localparam logic [2:0] IDX_PING    = 3'd2;
  localparam logic [2:0] IDX_PONG    = 3'd3;
  localparam logic [2:0] IDX_BA_BASE = 3'd4;

  localparam int CE_BIT  = 15;
  localparam int LE_BIT  = 14;
  localparam int PG_BIT  = 13;
  localparam int RDY_BIT = 15;
  localparam int DNE_BIT = 14;
  localparam int ERR_BIT = 13;
  localparam int DEPTH_FIELD = 13;

  typedef struct packed {
    logic rdy;
    logic dne;
    logic err;
  } page_flags_t;

  // hardware-owned flag: software may only clear, hardware set dominates
  function automatic logic c0_update(input logic old, input logic sw,
                                     input logic sw_bit, input logic hw_set);
    return (sw ? (old & sw_bit) : old) | hw_set;
  endfunction

  // page pointer: completion flip dominates a software write
  function automatic logic next_page(input logic cur, input logic flip,
                                     input logic sw, input logic sw_val);
    if (flip) return ~cur;
    if (sw) return sw_val;
    return cur;
  endfunction

  function automatic logic [15:0] pack_flags(input page_flags_t f,
                                             input logic [DEPTH_FIELD-1:0] d);
    return {f.rdy, f.dne, f.err, d};
  endfunction

  function automatic logic [3:0] lane_strobe(input logic [1:0] a, input logic little);
    logic [1:0] lane;
    lane = little ? a : (2'd3 - a);
    return 4'b0001 << lane;
  endfunction
endpackage

// File: rtl/pp_desc_regs.sv
module pp_desc_regs
  import pp_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int BW = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_idx,
  input  logic [15:0]                wr_data,
  input  logic [2:0]                 rd_idx,
  output logic [15:0]                rd_data,
  input  logic                       hw_done,
  input  logic                       hw_err,
  output logic                       ce_o,
  output logic                       le_o,
  output logic                       pg_o,
  output logic [NPAGE-1:0]           rdy_o,
  output logic [NPAGE-1:0][BW-1:0]   bd_o,
  output logic [NPAGE-1:0][AW-1:0]   ba_o
);
  localparam int HI_W = AW - 16;

  logic        ce_q, le_q, pg_q;
  page_flags_t flg_q [NPAGE];
  logic [BW-1:0] bd_q [NPAGE];
  logic [AW-1:0] ba_q [NPAGE];

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_idx == IDX_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b0;
      le_q <= 1'b0;
      pg_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ce_q <= wr_data[CE_BIT];
        le_q <= wr_data[LE_BIT];
      end
      pg_q <= next_page(pg_q, hw_done, ctrl_wr, wr_data[PG_BIT]);
    end
  end

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    localparam logic [2:0] FLAG_IDX = 3'(int'(IDX_PING) + p);
    localparam logic [2:0] LO_IDX   = 3'(int'(IDX_BA_BASE) + 2 * p);
    localparam logic [2:0] HI_IDX   = 3'(int'(IDX_BA_BASE) + 2 * p + 1);

    logic flag_wr, lo_wr, hi_wr, hw_hit;
    assign flag_wr = wr_en && (wr_idx == FLAG_IDX);
    assign lo_wr   = wr_en && (wr_idx == LO_IDX);
    assign hi_wr   = wr_en && (wr_idx == HI_IDX);
    assign hw_hit  = (pg_q == 1'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q[p] <= '0;
        bd_q[p]  <= '0;
        ba_q[p]  <= '0;
      end else begin
        if (flag_wr)
          flg_q[p].rdy <= wr_data[RDY_BIT];
        else if (hw_done && hw_hit)
          flg_q[p].rdy <= 1'b0;
        flg_q[p].dne <= c0_update(flg_q[p].dne, flag_wr, wr_data[DNE_BIT], hw_done && hw_hit);
        flg_q[p].err <= c0_update(flg_q[p].err, flag_wr, wr_data[ERR_BIT], hw_err && hw_hit);
        if (flag_wr) bd_q[p] <= BW'(wr_data[DEPTH_FIELD-1:0]);
        if (lo_wr) ba_q[p][15:0] <= wr_data;
        if (hi_wr) ba_q[p][AW-1:16] <= wr_data[HI_W-1:0];
      end
    end

    assign rdy_o[p] = flg_q[p].rdy;
    assign bd_o[p]  = bd_q[p];
    assign ba_o[p]  = ba_q[p];
  end

  assign ce_o = ce_q;
  assign le_o = le_q;
  assign pg_o = pg_q;

  always_comb begin
    case (rd_idx)
      IDX_CTRL: rd_data = {ce_q, le_q, pg_q, 13'd0};
      IDX_PING: rd_data = pack_flags(flg_q[0], DEPTH_FIELD'(bd_q[0]));
      IDX_PONG: rd_data = pack_flags(flg_q[1], DEPTH_FIELD'(bd_q[1]));
      3'd4:     rd_data = ba_q[0][15:0];
      3'd5:     rd_data = 16'(ba_q[0][AW-1:16]);
      3'd6:     rd_data = ba_q[1][15:0];
      3'd7:     rd_data = 16'(ba_q[1][AW-1:16]);
      default:  rd_data = 16'd0;
    endcase
  end

  AST_FLIP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |=> (pg_q != $past(pg_q))); // R4
  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done && !(wr_en && wr_idx == 3'(int'(IDX_PING) + int'(pg_q))) |=> !flg_q[$past(pg_q)].rdy); // R4
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |=> flg_q[$past(pg_q)].dne); // R8
  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err |=> flg_q[$past(pg_q)].err); // R7
  AST_NO_SW_SET_DNE: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_q[0].dne && !(hw_done && !pg_q) |=> !flg_q[0].dne); // R6
endmodule

// File: rtl/pp_page_engine.sv
module pp_page_engine #(
  parameter int AW = 32,
  parameter int BW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          rdy_act,
  input  logic [BW-1:0] bd_act,
  input  logic [AW-1:0] ba_act,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic          page_done,
  output logic          err_hit,
  output logic          irq
);
  logic [BW-1:0] off_q;
  logic          accept;

  function automatic logic [AW-1:0] byte_addr(input logic [AW-1:0] base,
                                               input logic [BW-1:0] off);
    return base + AW'(off);
  endfunction

  function automatic logic last_byte(input logic [BW-1:0] off, input logic [BW-1:0] depth);
    return off >= depth;
  endfunction

  assign req_valid = ce && rdy_act;
  assign req_addr  = byte_addr(ba_act, off_q);
  assign accept    = req_valid && mem_ack;
  assign page_done = accept && last_byte(off_q, bd_act);
  assign err_hit   = accept && mem_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= page_done;
      if (page_done)
        off_q <= '0;
      else if (accept)
        off_q <= off_q + BW'(1);
    end
  end

  AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(off_q)); // R10
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && !req_valid |=> $stable(off_q)); // R11
endmodule

// File: rtl/pp_lane_map.sv
module pp_lane_map
  import pp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic       little,
  input  logic [1:0] addr_lo,
  output logic [3:0] strb
);
  assign strb = valid ? lane_strobe(addr_lo, little) : 4'd0;

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(strb) == 1)); // R9
endmodule

// File: rtl/pingpong_dma_seq.sv
module pingpong_dma_seq
  import pp_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_wr_idx,
  input  logic [15:0]       cfg_wr_data,
  input  logic [2:0]        cfg_rd_idx,
  output logic [15:0]       cfg_rd_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_strb,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              done_irq
);
  logic                          ce, le, pg;
  logic [NPAGE-1:0]              rdy_vec;
  logic [NPAGE-1:0][DEPTH_W-1:0] bd_vec;
  logic [NPAGE-1:0][ADDR_W-1:0]  ba_vec;
  logic                          page_done, err_hit;

  pp_desc_regs #(.AW(ADDR_W), .BW(DEPTH_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
    .rd_idx(cfg_rd_idx), .rd_data(cfg_rd_data),
    .hw_done(page_done), .hw_err(err_hit),
    .ce_o(ce), .le_o(le), .pg_o(pg),
    .rdy_o(rdy_vec), .bd_o(bd_vec), .ba_o(ba_vec)
  );

  pp_page_engine #(.AW(ADDR_W), .BW(DEPTH_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .ce(ce), .rdy_act(rdy_vec[pg]), .bd_act(bd_vec[pg]), .ba_act(ba_vec[pg]),
    .mem_ack(mem_ack), .mem_err(mem_err),
    .req_valid(mem_req), .req_addr(mem_addr),
    .page_done(page_done), .err_hit(err_hit), .irq(done_irq)
  );

  pp_lane_map u_lanes (
    .clk(clk), .rst_n(rst_n),
    .valid(mem_req), .little(le), .addr_lo(mem_addr[1:0]),
    .strb(mem_strb)
  );
endmodule

// File: tb/pingpong_dma_seq_bench.sv
module pingpong_dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_idx = '0;
  logic [15:0] cfg_wr_data = '0;
  logic [2:0]  cfg_rd_idx = '0;
  logic [15:0] cfg_rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [3:0]  mem_strb;
  logic        mem_ack, mem_err;
  logic        done_irq;
  logic        ack_en = 1'b0, err_en = 1'b0;
  logic [31:0] err_addr = '0;

  int errors = 0, checks = 0, cyc = 0;
  int acc_cyc [0:63];
  int irq_cyc [0:15];
  int n_acc = 0, n_irq = 0;

  typedef struct { logic [31:0] a; logic [3:0] s; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_ack = ack_en;
  assign mem_err = err_en && mem_req && (mem_addr == err_addr);

  pingpong_dma_seq u_pingpong_dma_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_strb(mem_strb),
    .mem_ack(mem_ack), .mem_err(mem_err), .done_irq(done_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected byte requests for one page
  task automatic push_run(input logic [31:0] base, input int depth, input bit little);
    for (int i = 0; i <= depth; i++) begin
      exp_t e;
      logic [1:0] lane;
      e.a = base + 32'(i);
      lane = little ? e.a[1:0] : ~e.a[1:0];
      e.s = 4'b0001 << lane;
      exp_q.push_back(e);
    end
  endtask

  task automatic reg_wr(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = idx; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [15:0] exp, input string tag);
    cfg_rd_idx = idx;
    #1;
    chk(cfg_rd_data == exp, tag, 32'(cfg_rd_data), 32'(exp));
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R11 unexpected request", mem_addr, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(mem_addr == e.a, "R3 request address", mem_addr, e.a);
        chk(mem_strb == e.s, "R9 byte strobe", 32'(mem_strb), 32'(e.s));
      end
      if (n_acc < 64) acc_cyc[n_acc] = cyc;
      n_acc++;
    end
    if (rst_n && done_irq) begin
      if (n_irq < 16) irq_cyc[n_irq] = cyc;
      n_irq++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int w = 0; w < 8; w++) rd_chk(3'(w), 16'h0000, "R1 reset word");
    chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
    chk(done_irq == 1'b0, "R1 irq after reset", 32'(done_irq), 0);

    // R2 layout and read-back
    reg_wr(3'd4, 16'h0010); rd_chk(3'd4, 16'h0010, "R2 ping base low");
    reg_wr(3'd5, 16'h1000); rd_chk(3'd5, 16'h1000, "R2 ping base high");
    reg_wr(3'd6, 16'h0001); rd_chk(3'd6, 16'h0001, "R2 pong base low");
    reg_wr(3'd7, 16'h2000); rd_chk(3'd7, 16'h2000, "R2 pong base high");
    reg_wr(3'd1, 16'hFFFF); rd_chk(3'd1, 16'h0000, "R2 reserved word");
    reg_wr(3'd2, 16'hFFFF); rd_chk(3'd2, 16'h9FFF, "R2/R6 ping flags all ones");
    reg_wr(3'd2, 16'h0003); rd_chk(3'd2, 16'h0003, "R2 ping depth");
    reg_wr(3'd3, 16'h0002); rd_chk(3'd3, 16'h0002, "R2 pong depth");
    reg_wr(3'd0, 16'hFFFF); rd_chk(3'd0, 16'hE000, "R2 control word");
    chk(mem_req == 1'b0, "R3 no request without ready", 32'(mem_req), 0);
    reg_wr(3'd0, 16'h0000);

    // R4/R5 little-endian back-to-back pages
    ack_en = 1'b1;
    push_run(32'h1000_0010, 3, 1'b1);
    push_run(32'h2000_0001, 2, 1'b1);
    reg_wr(3'd2, 16'h8003);
    reg_wr(3'd3, 16'h8002);
    reg_wr(3'd0, 16'hC000);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all page bytes requested", 32'(exp_q.size()), 0);
    chk(acc_cyc[6] - acc_cyc[0] == 6, "R5 gapless page hand-over", 32'(acc_cyc[6] - acc_cyc[0]), 6);
    chk(n_irq == 2, "R4 one irq per page", 32'(n_irq), 2);
    chk(irq_cyc[0] == acc_cyc[3] + 1, "R4 ping irq timing", 32'(irq_cyc[0]), 32'(acc_cyc[3] + 1));
    chk(irq_cyc[1] == acc_cyc[6] + 1, "R4 pong irq timing", 32'(irq_cyc[1]), 32'(acc_cyc[6] + 1));
    chk(mem_req == 1'b0, "R5 idle when next page not ready", 32'(mem_req), 0);
    rd_chk(3'd2, 16'h4003, "R4 ping done and disarmed");
    rd_chk(3'd3, 16'h4002, "R4 pong done and disarmed");
    rd_chk(3'd0, 16'hC000, "R4 pointer flipped twice");

    // R6 clear-by-zero semantics
    reg_wr(3'd2, 16'h6003); rd_chk(3'd2, 16'h4003, "R6 write one keeps/cannot set");
    reg_wr(3'd2, 16'h0003); rd_chk(3'd2, 16'h0003, "R6 write zero clears done");
    reg_wr(3'd3, 16'h0002); rd_chk(3'd3, 16'h0002, "R6 pong clear");

    // R7/R9 big endian with an error response
    reg_wr(3'd4, 16'h0102); reg_wr(3'd5, 16'h0000);
    err_addr = 32'h0000_0104; err_en = 1'b1;
    push_run(32'h0000_0102, 5, 1'b0);
    reg_wr(3'd0, 16'h8000);
    reg_wr(3'd2, 16'h8005);
    repeat (10) @(negedge clk);
    err_en = 1'b0;
    chk(exp_q.size() == 0, "R9 big-endian run complete", 32'(exp_q.size()), 0);
    rd_chk(3'd2, 16'h6005, "R7 error latched, run completed");
    rd_chk(3'd0, 16'hA000, "R7 pointer on pong");
    chk(mem_req == 1'b0, "R5 pong not armed", 32'(mem_req), 0);

    // R10/R11 pause and resume
    ack_en = 1'b0;
    reg_wr(3'd6, 16'h0000); reg_wr(3'd7, 16'h3000);
    reg_wr(3'd0, 16'hE000);
    reg_wr(3'd3, 16'h8007);
    chk(mem_req && mem_addr == 32'h3000_0000, "R3 request held at page start", mem_addr, 32'h3000_0000);
    push_run(32'h3000_0000, 2, 1'b1);
    @(negedge clk); ack_en = 1'b1;
    repeat (3) @(negedge clk); ack_en = 1'b0;
    chk(mem_addr == 32'h3000_0003, "R3 offset after three accepts", mem_addr, 32'h3000_0003);
    reg_wr(3'd0, 16'h6000);
    chk(mem_req == 1'b0, "R10 request drops with enable", 32'(mem_req), 0);
    ack_en = 1'b1;
    repeat (5) @(negedge clk);
    ack_en = 1'b0;
    rd_chk(3'd0, 16'h6000, "R10 pointer kept while disabled");
    rd_chk(3'd3, 16'h8007, "R10/R11 page still pending");
    reg_wr(3'd0, 16'hE000);
    chk(mem_req && mem_addr == 32'h3000_0003, "R10 resume at same address", mem_addr, 32'h3000_0003);
    push_run(32'h3000_0003, 4, 1'b1);
    ack_en = 1'b1;
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R10 resumed page complete", 32'(exp_q.size()), 0);
    rd_chk(3'd3, 16'h4007, "R4 pong done after resume");
    rd_chk(3'd0, 16'hC000, "R4 pointer back to ping");

    // R8 completion collides with software clear
    reg_wr(3'd4, 16'h0040); reg_wr(3'd5, 16'h0000);
    reg_wr(3'd2, 16'h0001); rd_chk(3'd2, 16'h0001, "R6 ping cleared before collision");
    err_addr = 32'h0000_0041; err_en = 1'b1;
    push_run(32'h0000_0040, 1, 1'b1);
    reg_wr(3'd2, 16'h8001);
    reg_wr(3'd2, 16'h0001);
    repeat (3) @(negedge clk);
    err_en = 1'b0;
    rd_chk(3'd2, 16'h6001, "R8 hardware set wins over clear");
    chk(exp_q.size() == 0, "R8 collision page complete", 32'(exp_q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule